// File: doc/BRIEF.md
# LUT Region Refill Engine

The block rewrites rectangular regions of a set of two-dimensional page-translation lookup tables. Software hands it the byte address of the first region descriptor by writing the pointer register. The engine then walks the descriptor list through a single-outstanding memory read port. For each descriptor it fetches one 32-bit entry per LUT cell and drives a LUT write port. Cells are visited left to right within a row, and rows from top to bottom.

Each descriptor is five 32-bit words at a 16-byte-aligned address. Each LUT is `W_UNITS*32` cells wide and `H_UNITS*32` cells tall, and there are `NUM_LUTS` of them stacked in one flat LUT address space. A single status/interrupt lane (bits 7:0) reports list completion and errors. Writing zero to the pointer register cancels a walk in progress.

Top module: `lut_refill_engine`

## Requirements
- R1: After reset the status register (regAddr 1) reads 1: bit 0 is ready=1 and bit 1 is error=0. The interrupt register (regAddr 2) reads 0, `irq` is low, and no memory request is made.
- R2: A non-zero, 16-byte-aligned write to the pointer register (regAddr 0) while ready starts a walk, and ready is low in the following cycle. The descriptor words at pointer+0/4/8/12/16 are laid out as follows:
  - pointer+0: {y0[31:16], x0[15:0]}
  - pointer+4: {y1[31:16], x1[15:0]}
  - pointer+8: control, with bit 0 = enable and bits 11:8 = LUT select
  - pointer+12: data pointer
  - pointer+16: next pointer
- R3: Entry k of an enabled descriptor is read from data+4k. It is written to LUT address `sel*W*H + y*W + x`, with (x,y) taken in row-major order from (x0,y0) to (x1,y1), where W = W_UNITS*32 and H = H_UNITS*32.
- R4: After a descriptor the engine follows its next pointer, and a next pointer of 0 ends the list. At that point interrupt bit 0 (list done) is set and ready returns high, only after the last LUT write.
- R5: A descriptor whose enable bit is 0 writes nothing, and the walk continues with its next pointer.
- R6: Any of the following sets error (status bit 1) and interrupt bit 1, returns to ready without setting list done, and makes no write for the offending descriptor:
  - a start or next pointer with low 4 bits non-zero
  - a data pointer with low 4 bits non-zero
  - x1<x0 or y1<y0
  - x1>=W or y1>=H
  - a LUT select >= NUM_LUTS
- R7: Writing 0 to the pointer register stops the walk, and no LUT write occurs from that cycle on. Ready returns once any accepted read has been answered, with error cleared and list done not set. A later walk then proceeds normally.
- R8: A non-zero write to the pointer register while not ready is ignored.
- R9: Writing the interrupt register clears exactly the bits written as 1. `irq` is the OR of the interrupt bits.
- R10: A memory request stays asserted with a stable, word-aligned address until it is accepted. The walk tolerates any stall pattern on the ready input and any response latency.
- R11: The geometry register (regAddr 3) reads W_UNITS in bits 3:0 and H_UNITS in bits 7:4.
- R12: A valid start clears an error left by a previous walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| memRdValid | output | 1 | Memory read request valid |
| memRdReady | input | 1 | Memory read request accepted |
| memRdAddr | output | 32 | Memory read byte address |
| memRspValid | input | 1 | Memory read response valid |
| memRspData | input | 32 | Memory read response data |
| lutWrEn | output | 1 | LUT write strobe |
| lutWrAddr | output | LUT_AW | Flat LUT write address |
| lutWrData | output | 32 | LUT write data |
| irq | output | 1 | OR of interrupt lane bits |

## Verification
The embedded properties check several protocol rules on every cycle:
- the read request holds until it is accepted, and its address is word aligned
- no LUT write happens while the engine is idle or in the cycle of an abort
- list done and error rise only together with ready

Only the bench's scenarios can show the following:
- the row-major placement of entries across LUTs and edge rectangles
- the skipping of disabled descriptors
- the error cases leaving the tables untouched
- an abort leaving exactly a prefix of the region written

They are compared against a bench-side model of the tables.

// File: rtl/refill_pkg.sv
package refill_pkg;

  localparam logic [1:0] REG_PTR    = 2'd0;
  localparam logic [1:0] REG_STATUS = 2'd1;
  localparam logic [1:0] REG_IRQ    = 2'd2;
  localparam logic [1:0] REG_GEOM   = 2'd3;

  localparam int IRQ_DONE_BIT = 0;
  localparam int IRQ_ERR_BIT  = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_CHECK,
    ST_EREQ, ST_EWAIT, ST_NEXT, ST_DRAIN
  } refillState_t;

  typedef struct packed {
    logic startDesc;
    logic followNext;
    logic loadWord;
    logic enterRect;
    logic stepEntry;
  } dpCtrl_t;

endpackage

// File: rtl/refill_dp.sv
module refill_dp
  import refill_pkg::*;
#(
  parameter int LUT_W    = 32,
  parameter int LUT_H    = 32,
  parameter int NUM_LUTS = 2,
  parameter int LUT_AW   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              entryPhase,
  input  logic [31:0]       kickPtr,
  input  logic [31:0]       rspData,
  output logic [31:0]       reqAddr,
  output logic [31:0]       descPtrOut,
  output logic [LUT_AW-1:0] lutAddr,
  output logic              wordLast,
  output logic              descBad,
  output logic              startBit,
  output logic              lastEntry,
  output logic              nextZero,
  output logic              nextMisaligned
);
  localparam int CW      = 16;
  localparam int IDX_W   = 3;
  localparam int LAST_WD = 4;
  localparam int LUT_SZ  = LUT_W * LUT_H;

  logic [31:0]    descPtr, dataPtr, nextPtr, fetchAddr;
  logic [IDX_W-1:0] wordIdx;
  logic [CW-1:0]  xa, ya, xb, yb, curX, curY;
  logic [3:0]     lutId;
  logic           enBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr <= '0; dataPtr <= '0; nextPtr <= '0; fetchAddr <= '0;
      wordIdx <= '0; xa <= '0; ya <= '0; xb <= '0; yb <= '0;
      curX <= '0; curY <= '0; lutId <= '0; enBit <= 1'b0;
    end else begin
      if (ctl.startDesc) begin
        descPtr <= kickPtr;
        wordIdx <= '0;
      end else if (ctl.followNext) begin
        descPtr <= nextPtr;
        wordIdx <= '0;
      end
      if (ctl.loadWord) begin
        case (wordIdx)
          3'd0: begin xa <= rspData[15:0]; ya <= rspData[31:16]; end
          3'd1: begin xb <= rspData[15:0]; yb <= rspData[31:16]; end
          3'd2: begin enBit <= rspData[0]; lutId <= rspData[11:8]; end
          3'd3: dataPtr <= rspData;
          default: nextPtr <= rspData;
        endcase
        wordIdx <= wordIdx + 1'b1;
      end
      if (ctl.enterRect) begin
        curX      <= xa;
        curY      <= ya;
        fetchAddr <= dataPtr;
      end else if (ctl.stepEntry) begin
        if (curX == xb) begin
          curX <= xa;
          curY <= curY + 1'b1;
        end else begin
          curX <= curX + 1'b1;
        end
        fetchAddr <= fetchAddr + 32'd4;
      end
    end
  end

  always_comb begin
    reqAddr = entryPhase ? fetchAddr : (descPtr + {27'd0, wordIdx, 2'b00});
    lutAddr = LUT_AW'(lutId) * LUT_AW'(LUT_SZ)
            + LUT_AW'(curY) * LUT_AW'(LUT_W)
            + LUT_AW'(curX);
  end

  assign descPtrOut     = descPtr;
  assign wordLast       = (wordIdx == IDX_W'(LAST_WD));
  assign startBit       = enBit;
  assign lastEntry      = (curX == xb) && (curY == yb);
  assign nextZero       = (nextPtr == 32'd0);
  assign nextMisaligned = (nextPtr[3:0] != 4'd0);
  assign descBad        = (xb < xa) || (yb < ya)
                        || (32'(xb) >= LUT_W) || (32'(yb) >= LUT_H)
                        || (32'(lutId) >= NUM_LUTS)
                        || (dataPtr[3:0] != 4'd0);

  // Walk stays inside the rectangle that was accepted.
  AST_WALK_IN_RECT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepEntry |-> (curY <= yb) && (curX <= xb) && !descBad) // R3
    else $error("walk left rectangle");

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  input  logic        memRdReady,
  input  logic        memRspValid,
  input  logic        wordLast,
  input  logic        descBad,
  input  logic        startBit,
  input  logic        lastEntry,
  input  logic        nextZero,
  input  logic        nextMisaligned,
  output dpCtrl_t     ctl,
  output logic        entryPhase,
  output logic        memRdValid,
  output logic        lutWrEn,
  output logic        ready,
  output logic        errFlag,
  output logic [7:0]  irqStatus
);
  refillState_t state, stateNext;
  logic ptrWrite, kickNow, kickBad, abortNow, outstanding;
  logic errSet, doneSet;
  logic [7:0] irqClear, irqSet;

  assign ptrWrite   = regWrEn && (regAddr == REG_PTR);
  assign kickNow    = ptrWrite && (regWrData != 32'd0) && (state == ST_IDLE);
  assign kickBad    = regWrData[3:0] != 4'd0;
  assign abortNow   = ptrWrite && (regWrData == 32'd0);
  assign ready      = (state == ST_IDLE);
  assign entryPhase = (state == ST_EREQ);
  assign memRdValid = (state == ST_DREQ) || (state == ST_EREQ);
  assign outstanding =
      (((state == ST_DREQ) || (state == ST_EREQ)) && memRdReady) ||
      (((state == ST_DWAIT) || (state == ST_EWAIT) || (state == ST_DRAIN)) && !memRspValid);

  always_comb begin
    stateNext = state;
    ctl       = '0;
    lutWrEn   = 1'b0;
    errSet    = 1'b0;
    doneSet   = 1'b0;
    case (state)
      ST_IDLE:
        if (kickNow) begin
          if (kickBad) errSet = 1'b1;
          else begin
            ctl.startDesc = 1'b1;
            stateNext     = ST_DREQ;
          end
        end
      ST_DREQ: if (memRdReady) stateNext = ST_DWAIT;
      ST_DWAIT:
        if (memRspValid) begin
          ctl.loadWord = 1'b1;
          stateNext    = wordLast ? ST_CHECK : ST_DREQ;
        end
      ST_CHECK:
        if (descBad) begin
          errSet    = 1'b1;
          stateNext = ST_IDLE;
        end else if (!startBit) begin
          stateNext = ST_NEXT;
        end else begin
          ctl.enterRect = 1'b1;
          stateNext     = ST_EREQ;
        end
      ST_EREQ: if (memRdReady) stateNext = ST_EWAIT;
      ST_EWAIT:
        if (memRspValid) begin
          lutWrEn = 1'b1;
          if (lastEntry) stateNext = ST_NEXT;
          else begin
            ctl.stepEntry = 1'b1;
            stateNext     = ST_EREQ;
          end
        end
      ST_NEXT:
        if (nextZero) begin
          doneSet   = 1'b1;
          stateNext = ST_IDLE;
        end else if (nextMisaligned) begin
          errSet    = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ctl.followNext = 1'b1;
          stateNext      = ST_DREQ;
        end
      ST_DRAIN: if (memRspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
    if (abortNow && (state != ST_IDLE)) begin
      ctl       = '0;
      lutWrEn   = 1'b0;
      errSet    = 1'b0;
      doneSet   = 1'b0;
      stateNext = outstanding ? ST_DRAIN : ST_IDLE;
    end
  end

  always_comb begin
    irqClear = (regWrEn && (regAddr == REG_IRQ)) ? regWrData[7:0] : 8'd0;
    irqSet   = '0;
    irqSet[IRQ_DONE_BIT] = doneSet;
    irqSet[IRQ_ERR_BIT]  = errSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      errFlag   <= 1'b0;
      irqStatus <= '0;
    end else begin
      state     <= stateNext;
      irqStatus <= (irqStatus & ~irqClear) | irqSet;
      if (abortNow)     errFlag <= 1'b0;
      else if (errSet)  errFlag <= 1'b1;
      else if (kickNow) errFlag <= 1'b0;
    end
  end

  AST_NO_WRITE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (ready || abortNow) |-> !lutWrEn) // R7
    else $error("LUT write while idle or aborting");

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[IRQ_DONE_BIT]) |-> ready) // R4
    else $error("list done raised while busy");

  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ready && irqStatus[IRQ_ERR_BIT]) // R6
    else $error("error without stop");

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && !memRdReady && !abortNow |=> memRdValid) // R10
    else $error("request dropped before accept");

endmodule

// File: rtl/lut_refill_engine.sv
module lut_refill_engine
  import refill_pkg::*;
#(
  parameter  int W_UNITS  = 1,
  parameter  int H_UNITS  = 1,
  parameter  int NUM_LUTS = 2,
  localparam int LUT_W    = W_UNITS * 32,
  localparam int LUT_H    = H_UNITS * 32,
  localparam int LUT_AW   = $clog2(NUM_LUTS * LUT_W * LUT_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memRdValid,
  input  logic              memRdReady,
  output logic [31:0]       memRdAddr,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              lutWrEn,
  output logic [LUT_AW-1:0] lutWrAddr,
  output logic [31:0]       lutWrData,
  output logic              irq
);
  dpCtrl_t    ctl;
  logic       entryPhase, ready, errFlag;
  logic       wordLast, descBad, startBit, lastEntry, nextZero, nextMisaligned;
  logic [7:0] irqStatus;
  logic [31:0] descPtr;

  refill_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .memRdReady(memRdReady), .memRspValid(memRspValid),
    .wordLast(wordLast), .descBad(descBad), .startBit(startBit),
    .lastEntry(lastEntry), .nextZero(nextZero), .nextMisaligned(nextMisaligned),
    .ctl(ctl), .entryPhase(entryPhase), .memRdValid(memRdValid),
    .lutWrEn(lutWrEn), .ready(ready), .errFlag(errFlag), .irqStatus(irqStatus)
  );

  refill_dp #(.LUT_W(LUT_W), .LUT_H(LUT_H), .NUM_LUTS(NUM_LUTS), .LUT_AW(LUT_AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .entryPhase(entryPhase),
    .kickPtr(regWrData), .rspData(memRspData),
    .reqAddr(memRdAddr), .descPtrOut(descPtr), .lutAddr(lutWrAddr),
    .wordLast(wordLast), .descBad(descBad), .startBit(startBit),
    .lastEntry(lastEntry), .nextZero(nextZero), .nextMisaligned(nextMisaligned)
  );

  assign lutWrData = memRspData;
  assign irq       = |irqStatus;

  always_comb begin
    case (regAddr)
      REG_PTR:    regRdData = descPtr;
      REG_STATUS: regRdData = {30'd0, errFlag, ready};
      REG_IRQ:    regRdData = {24'd0, irqStatus};
      default:    regRdData = {24'd0, 4'(H_UNITS), 4'(W_UNITS)};
    endcase
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> (memRdAddr[1:0] == 2'b00)) // R10
    else $error("unaligned memory request");

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && !memRdReady && !(regWrEn && regAddr == REG_PTR && regWrData == 32'd0)
      |=> $stable(memRdAddr)) // R10
    else $error("request address moved before accept");

endmodule

// File: tb/lut_refill_engine_test.sv
module lut_refill_engine_test;
  localparam int LW = 32;
  localparam int LH = 32;
  localparam int NL = 2;
  localparam int LSZ = LW * LH;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic memRdValid, memRdReady, memRspValid;
  logic [31:0] memRdAddr, memRspData, lutWrData;
  logic lutWrEn, irq;
  logic [AW-1:0] lutWrAddr;

  lut_refill_engine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .memRdValid(memRdValid), .memRdReady(memRdReady), .memRdAddr(memRdAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .lutWrEn(lutWrEn), .lutWrAddr(lutWrAddr), .lutWrData(lutWrData), .irq(irq)
  );

  always #10 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [31:0] lutModel [0:NL*LSZ-1];
  logic [31:0] expLut [0:NL*LSZ-1];
  int checks = 0;
  int fails = 0;
  int writesTotal = 0;
  logic stallOn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic pending = 1'b0;
  logic [31:0] pendAddr = 32'd0;
  int pendDelay = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory and LUT models: sample settled values at the edge, drive at negedge.
  initial begin
    memRdReady = 1'b0; memRspValid = 1'b0; memRspData = 32'd0;
    forever begin
      @(posedge clk);
      if (!rstN) pending = 1'b0;
      else begin
        if (memRdValid && memRdReady) begin
          pending = 1'b1;
          pendAddr = memRdAddr;
          pendDelay = int'(lfsr[2:1]) % 3;
        end
        if (lutWrEn) begin
          lutModel[lutWrAddr] = lutWrData;
          writesTotal++;
        end
      end
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      memRspValid = 1'b0;
      if (pending) begin
        if (pendDelay == 0) begin
          memRspValid = 1'b1;
          memRspData = mem[pendAddr[11:2]];
          pending = 1'b0;
        end else pendDelay--;
      end
      memRdReady = stallOn ? lfsr[0] : 1'b1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitReady(input string req);
    logic [31:0] s;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      regRead(2'd1, s);
      if (s[0]) return;
    end
    chk(req, 32'd0, 32'd1);
  endtask

  task automatic putDesc(input int base, input int x0, input int y0, input int x1, input int y1,
                         input int en, input int sel, input int dataPtr, input int nextPtr);
    mem[base/4]     = {16'(y0), 16'(x0)};
    mem[base/4 + 1] = {16'(y1), 16'(x1)};
    mem[base/4 + 2] = {20'd0, 4'(sel), 7'd0, 1'(en)};
    mem[base/4 + 3] = 32'(dataPtr);
    mem[base/4 + 4] = 32'(nextPtr);
  endtask

  task automatic putData(input int ptr, input int n, input int seed);
    for (int k = 0; k < n; k++) mem[ptr/4 + k] = 32'(seed + k);
  endtask

  task automatic expRect(input int sel, input int x0, input int y0, input int x1, input int y1,
                         input int ptr, input int limit);
    int k = 0;
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        if (k < limit) expLut[sel*LSZ + y*LW + x] = mem[ptr/4 + k];
        k++;
      end
  endtask

  task automatic compareLut(input string req);
    for (int i = 0; i < NL*LSZ; i++) chk(req, lutModel[i], expLut[i]);
  endtask

  task automatic checkStatus(input string req, input logic [31:0] st, input logic [31:0] iq);
    logic [31:0] v;
    @(negedge clk);
    regRead(2'd1, v); chk({req, " status"}, v, st);
    regRead(2'd2, v); chk({req, " irq reg"}, v, iq);
    chk({req, " irq pin"}, {31'd0, irq}, {31'd0, iq != 0});
  endtask

  initial begin
    logic [31:0] v;
    int w, h, run, sel, x0, y0, x1b, y1b, en, snap, kickW, n;
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    for (int i = 0; i < NL*LSZ; i++) begin lutModel[i] = 32'd0; expLut[i] = 32'd0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkStatus("R1", 32'd1, 32'd0);
    chk("R1 no request", {31'd0, memRdValid}, 32'd0);
    // R11 geometry
    regRead(2'd3, v); chk("R11 geometry", v, 32'h11);

    // R3/R4/R5 sweep of rectangle sizes, two-descriptor chains
    for (w = 1; w <= 4; w++)
      for (h = 1; h <= 3; h++) begin
        run = (w-1)*3 + h - 1;
        stallOn = run[0];
        sel = run % 2;
        x0 = (run*5) % 28; y0 = run*2;
        en = (h != 2) ? 1 : 0;
        putDesc(16'h010, x0, y0, x0+w-1, y0+h-1, 1, sel, 16'h200, 16'h040);
        putDesc(16'h040, LW-w, LH-h, LW-1, LH-1, en, 1-sel, 16'h400, 0);
        putData(16'h200, w*h, (run << 16) | 16'h1000);
        putData(16'h400, w*h, (run << 16) | 16'h2000);
        putDesc(16'h070, 0, 0, 31, 0, 1, 0, 16'h600, 0);
        putData(16'h600, 32, 32'h0BAD0000);
        regWrite(2'd0, 32'h010);
        regRead(2'd1, v); chk("R2 ready low after start", {31'd0, v[0]}, 32'd0);
        if (run == 5) regWrite(2'd0, 32'h070); // R8 ignored while busy
        waitReady("R4 completion");
        expRect(sel, x0, y0, x0+w-1, y0+h-1, 16'h200, 1 << 20);
        if (en == 1) expRect(1-sel, LW-w, LH-h, LW-1, LH-1, 16'h400, 1 << 20);
        compareLut(run == 5 ? "R8 LUT" : (en == 1 ? "R3 LUT" : "R5 LUT"));
        checkStatus("R4", 32'd1, 32'd1);
        regWrite(2'd2, 32'd2);
        checkStatus("R9 other bit kept", 32'd1, 32'd1);
        regWrite(2'd2, 32'd1);
        checkStatus("R9 cleared", 32'd1, 32'd0);
      end

    // R6 error cases
    for (int e = 0; e < 7; e++) begin
      stallOn = e[0];
      putData(16'h200, 4, 32'h00E00000 + (e << 8));
      case (e)
        1: putDesc(16'h010, 5, 3, 4, 3, 1, 0, 16'h200, 0);
        2: putDesc(16'h010, 3, 6, 3, 5, 1, 0, 16'h200, 0);
        3: putDesc(16'h010, 30, 3, 32, 3, 1, 0, 16'h200, 0);
        4: putDesc(16'h010, 1, 1, 2, 2, 1, 2, 16'h200, 0);
        5: putDesc(16'h010, 1, 1, 2, 2, 1, 1, 16'h204, 0);
        6: putDesc(16'h010, 10, 20, 11, 21, 1, 1, 16'h200, 16'h044);
        default: ;
      endcase
      regWrite(2'd0, e == 0 ? 32'h018 : 32'h010);
      waitReady("R6 stop");
      if (e == 6) expRect(1, 10, 20, 11, 21, 16'h200, 4);
      compareLut("R6 LUT");
      checkStatus("R6", 32'd3, 32'd2);
      regWrite(2'd2, 32'd2);
    end

    // R12 valid start clears error
    putDesc(16'h010, 6, 6, 7, 6, 1, 0, 16'h200, 0);
    putData(16'h200, 2, 32'h00C0FFEE);
    regWrite(2'd0, 32'h010);
    regRead(2'd1, v); chk("R12 error cleared on start", v, 32'd0);
    waitReady("R12 completion");
    expRect(0, 6, 6, 7, 6, 16'h200, 4);
    compareLut("R12 LUT");
    checkStatus("R12", 32'd1, 32'd1);
    regWrite(2'd2, 32'd1);

    // R7 zero write while idle clears error
    regWrite(2'd0, 32'h018);
    checkStatus("R7 pre", 32'd3, 32'd2);
    regWrite(2'd2, 32'd2);
    regWrite(2'd0, 32'd0);
    checkStatus("R7 idle clear", 32'd1, 32'd0);

    // R7 abort mid-walk, prefix written, nothing after
    stallOn = 1'b1;
    putDesc(16'h010, 0, 8, 31, 11, 1, 0, 16'h800, 0);
    putData(16'h800, 128, 32'h00AB0000);
    kickW = writesTotal;
    regWrite(2'd0, 32'h010);
    repeat (60) @(negedge clk);
    snap = writesTotal;
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'd0;
    @(negedge clk);
    regWrEn = 1'b0;
    waitReady("R7 abort return");
    repeat (20) @(negedge clk);
    chk("R7 no write after abort", 32'(writesTotal), 32'(snap));
    n = snap - kickW;
    chk("R7 partial progress", {31'd0, (n > 0) && (n < 128)}, 32'd1);
    expRect(0, 0, 8, 31, 11, 16'h800, n);
    compareLut("R7 prefix LUT");
    checkStatus("R7 abort", 32'd1, 32'd0);

    // R7/R10 walk after abort with stalls
    putDesc(16'h010, 20, 20, 22, 22, 1, 1, 16'h200, 16'h040);
    putDesc(16'h040, 0, 0, 1, 0, 1, 0, 16'h400, 0);
    putData(16'h200, 9, 32'h00770000);
    putData(16'h400, 2, 32'h00880000);
    regWrite(2'd0, 32'h010);
    waitReady("R10 completion");
    expRect(1, 20, 20, 22, 22, 16'h200, 16);
    expRect(0, 0, 0, 1, 0, 16'h400, 16);
    compareLut("R10 LUT after abort");
    checkStatus("R4 after abort", 32'd1, 32'd1);

    summary();
    $finish;
  end
endmodule